// File: doc/BRIEF.md
# Layer Transfer Count Calculator

This block works out how many 64-byte memory transactions one neural-network layer needs for a single kind of traffic: reading its weights, reading its input activations, or writing its output activations. The caller presents the layer's three byte sizes, its own id and the id of the layer it consumes from, the id of its predecessor and the consumer id of its successor, its position in the network, the network length and the capacity of the on-chip activation buffer. It then pulses a start strobe together with a traffic-kind select.

Input and output traffic shrink only when two adjacent layers form a producer/consumer pair. In that case the on-chip buffer carries up to its capacity in bytes, and only the remainder goes to memory. Weight traffic never shrinks. The result is registered and comes out with a single-cycle valid pulse one clock after the strobe. The count then holds until the next strobe.

Top module: `ltc_top`

## Requirements
- R1: While reset is high and on the first falling clock edge after it is released, `xfer_valid` is 0 and `xfer_count` is 0.
- R2: `xfer_valid` is high in exactly the cycle after a cycle in which `start` was high. Strobes on consecutive cycles keep it high on consecutive cycles. It is low after any cycle without `start`.
- R3: Without `start`, `xfer_count` keeps its last value even if every other input changes.
- R4: With kind 0 (weight read), the count is `weight_bytes` divided by 64 and rounded down. The buffer and all ids are ignored.
- R5: With kind 1 (input read), the count is `input_bytes` divided by 64 and rounded down when `layer_idx` is 0 or when `prev_id` differs from `dep_id`.
- R6: With kind 1, when `layer_idx` is not 0, `prev_id` equals `dep_id` and `input_bytes` is at most `buf_bytes` (equality included), the count is 0.
- R7: With kind 1, when `layer_idx` is not 0, `prev_id` equals `dep_id` and `input_bytes` exceeds `buf_bytes`, the count is (`input_bytes` - `buf_bytes`) divided by 64 and rounded down.
- R8: With kind 2 (output write), the count is `output_bytes` divided by 64 and rounded down when the layer is the last one (`layer_idx` + 1 >= `layer_total`) or when `next_dep_id` differs from `layer_id`.
- R9: With kind 2, for a layer that is not the last one and whose `next_dep_id` equals `layer_id`, the count is 0 if `output_bytes` <= `buf_bytes`. Otherwise it is (`output_bytes` - `buf_bytes`) divided by 64 and rounded down.
- R10: At layer 0, `prev_id` has no effect on an input count. At the last layer, `next_dep_id` has no effect on an output count.
- R11: With kind 3 (unused), the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Compute request strobe |
| kind | input | 2 | Traffic kind: 0 weights, 1 inputs, 2 outputs, 3 unused |
| weight_bytes | input | SIZE_W | Layer weight size in bytes |
| input_bytes | input | SIZE_W | Layer input size in bytes |
| output_bytes | input | SIZE_W | Layer output size in bytes |
| buf_bytes | input | SIZE_W | On-chip buffer capacity in bytes |
| layer_id | input | ID_W | Id of this layer |
| dep_id | input | ID_W | Id of the layer this one consumes |
| prev_id | input | ID_W | Id of the preceding layer |
| next_dep_id | input | ID_W | Consumer id of the following layer |
| layer_idx | input | IDX_W | Position of this layer, 0 based |
| layer_total | input | IDX_W | Number of layers in the network |
| xfer_count | output | SIZE_W-6 | Transaction count |
| xfer_valid | output | 1 | One-cycle pulse marking a fresh count |

## Verification
Two behaviours can land in the same cycle. One is a boundary position, where the neighbour comparison must be skipped. The other is a matching neighbour id that would otherwise enable buffer reuse. The bench provokes this by driving layer 0 with `prev_id` equal to `dep_id`, and the last layer with `next_dep_id` equal to `layer_id`. It expects the full unreduced count in both cases. A second overlap is a new strobe arriving in the same cycle that the previous result is presented. Back-to-back strobes with different kinds are judged each clock against a behavioural model: the valid flag must stay high and the count must change every cycle.

// File: rtl/ltc_pkg.sv
package ltc_pkg;
  localparam int BEAT_SHIFT = 6;

  typedef enum logic [1:0] {
    XK_WEIGHT = 2'd0,
    XK_INPUT  = 2'd1,
    XK_OUTPUT = 2'd2,
    XK_NONE   = 2'd3
  } xfer_kind_e;
endpackage

// File: rtl/ltc_link_detect.sv
module ltc_link_detect #(
  parameter int ID_W  = 8,
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] layer_idx,
  input  logic [IDX_W-1:0] layer_total,
  input  logic [ID_W-1:0]  layer_id,
  input  logic [ID_W-1:0]  dep_id,
  input  logic [ID_W-1:0]  prev_id,
  input  logic [ID_W-1:0]  next_dep_id,
  output logic             in_linked,
  output logic             out_linked
);
  localparam int WIDE = IDX_W + 1;

  logic            is_first;
  logic            is_last;
  logic [WIDE-1:0] idx_plus;

  always_comb begin
    idx_plus = {1'b0, layer_idx} + WIDE'(1);
    is_first = (layer_idx == '0);
    is_last  = (idx_plus >= {1'b0, layer_total});
    // Neighbour ids are only consulted when the neighbour exists.
    in_linked  = is_first ? 1'b0 : (prev_id == dep_id);
    out_linked = is_last  ? 1'b0 : (next_dep_id == layer_id);
  end
endmodule

// File: rtl/ltc_reuse_trim.sv
module ltc_reuse_trim #(
  parameter int SIZE_W = 32
) (
  input  logic [SIZE_W-1:0]  bytes,
  input  logic [SIZE_W-1:0]  buf_bytes,
  input  logic               linked,
  output logic [SIZE_W-7:0]  beats
);
  logic [SIZE_W-1:0] spill;
  logic              fits;

  always_comb begin
    fits = (bytes <= buf_bytes);
    if (!linked)   spill = bytes;
    else if (fits) spill = '0;
    else           spill = bytes - buf_bytes;
    beats = spill[SIZE_W-1:6];
  end

  // R7/R9 guard: trimming never raises the byte count.
  always_comb begin
    a_r7_trim_bounded: assert (beats <= bytes[SIZE_W-1:6]);
  end
endmodule

// File: rtl/ltc_top.sv
module ltc_top #(
  parameter int SIZE_W = 32,
  parameter int ID_W   = 8,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        kind,
  input  logic [SIZE_W-1:0] weight_bytes,
  input  logic [SIZE_W-1:0] input_bytes,
  input  logic [SIZE_W-1:0] output_bytes,
  input  logic [SIZE_W-1:0] buf_bytes,
  input  logic [ID_W-1:0]   layer_id,
  input  logic [ID_W-1:0]   dep_id,
  input  logic [ID_W-1:0]   prev_id,
  input  logic [ID_W-1:0]   next_dep_id,
  input  logic [IDX_W-1:0]  layer_idx,
  input  logic [IDX_W-1:0]  layer_total,
  output logic [SIZE_W-7:0] xfer_count,
  output logic              xfer_valid
);
  import ltc_pkg::*;

  localparam int CNT_W = SIZE_W - BEAT_SHIFT;
  localparam int NCH   = 2; // channel 0: inputs, channel 1: outputs

  logic             in_linked, out_linked;
  logic [SIZE_W-1:0] ch_bytes [NCH];
  logic             ch_link  [NCH];
  logic [CNT_W-1:0] ch_beats [NCH];
  logic [CNT_W-1:0] next_count;
  xfer_kind_e       kind_e;

  ltc_link_detect #(.ID_W(ID_W), .IDX_W(IDX_W)) link_i (
    .layer_idx   (layer_idx),
    .layer_total (layer_total),
    .layer_id    (layer_id),
    .dep_id      (dep_id),
    .prev_id     (prev_id),
    .next_dep_id (next_dep_id),
    .in_linked   (in_linked),
    .out_linked  (out_linked)
  );

  assign ch_bytes[0] = input_bytes;
  assign ch_link[0]  = in_linked;
  assign ch_bytes[1] = output_bytes;
  assign ch_link[1]  = out_linked;

  for (genvar g = 0; g < NCH; g++) begin : g_trim
    ltc_reuse_trim #(.SIZE_W(SIZE_W)) trim_i (
      .bytes     (ch_bytes[g]),
      .buf_bytes (buf_bytes),
      .linked    (ch_link[g]),
      .beats     (ch_beats[g])
    );
  end

  always_comb begin
    kind_e = xfer_kind_e'(kind);
    unique case (kind_e)
      XK_WEIGHT: next_count = weight_bytes[SIZE_W-1:BEAT_SHIFT];
      XK_INPUT:  next_count = ch_beats[0];
      XK_OUTPUT: next_count = ch_beats[1];
      default:   next_count = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_count <= '0;
      xfer_valid <= 1'b0;
    end else begin
      xfer_valid <= start;
      if (start) xfer_count <= next_count;
    end
  end

  a_r2_pulse_after_start: assert property (@(posedge clk) disable iff (rst)
    start |=> xfer_valid);
  a_r2_quiet_without_start: assert property (@(posedge clk) disable iff (rst)
    !start |=> !xfer_valid);
  a_r3_hold_count: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(xfer_count));
  a_r4_weight_count: assert property (@(posedge clk) disable iff (rst)
    (start && kind == 2'd0) |=> (xfer_count == $past(weight_bytes[SIZE_W-1:6])));
  a_r6_fit_zero: assert property (@(posedge clk) disable iff (rst)
    (start && kind == 2'd1 && layer_idx != '0 && prev_id == dep_id &&
     input_bytes <= buf_bytes) |=> (xfer_count == '0));
  a_r10_first_layer_full: assert property (@(posedge clk) disable iff (rst)
    (start && kind == 2'd1 && layer_idx == '0) |=>
    (xfer_count == $past(input_bytes[SIZE_W-1:6])));
  a_r11_unused_kind_zero: assert property (@(posedge clk) disable iff (rst)
    (start && kind == 2'd3) |=> (xfer_count == '0));
endmodule

// File: tb/ltc_top_tb_top.sv
module ltc_top_tb_top;
  localparam int SIZE_W = 32;
  localparam int ID_W   = 8;
  localparam int IDX_W  = 10;
  localparam int CNT_W  = SIZE_W - 6;
  localparam time CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [1:0]        kind = '0;
  logic [SIZE_W-1:0] weight_bytes = '0, input_bytes = '0, output_bytes = '0, buf_bytes = '0;
  logic [ID_W-1:0]   layer_id = '0, dep_id = '0, prev_id = '0, next_dep_id = '0;
  logic [IDX_W-1:0]  layer_idx = '0, layer_total = '0;
  logic [CNT_W-1:0]  xfer_count;
  logic              xfer_valid;

  int vectors = 0;
  int miscompares = 0;
  longint exp_count = 0;
  bit exp_valid = 1'b0;
  string exp_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ltc_top #(.SIZE_W(SIZE_W), .ID_W(ID_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .kind(kind),
    .weight_bytes(weight_bytes), .input_bytes(input_bytes),
    .output_bytes(output_bytes), .buf_bytes(buf_bytes),
    .layer_id(layer_id), .dep_id(dep_id), .prev_id(prev_id),
    .next_dep_id(next_dep_id), .layer_idx(layer_idx),
    .layer_total(layer_total), .xfer_count(xfer_count), .xfer_valid(xfer_valid)
  );

  // Behavioural reference, straight from the requirement text.
  function automatic longint model_count();
    longint w = weight_bytes, i = input_bytes, o = output_bytes, b = buf_bytes;
    int idx = layer_idx, tot = layer_total;
    case (kind)
      2'd0: return w / 64;
      2'd1: begin
        if (idx == 0 || prev_id != dep_id) return i / 64;
        if (i <= b) return 0;
        return (i - b) / 64;
      end
      2'd2: begin
        if (idx + 1 >= tot || next_dep_id != layer_id) return o / 64;
        if (o <= b) return 0;
        return (o - b) / 64;
      end
      default: return 0;
    endcase
  endfunction

  task automatic compare();
    vectors++;
    if (xfer_valid !== exp_valid || longint'(xfer_count) != exp_count) begin
      miscompares++;
      $display("FAIL %s: valid=%0b count=%0d expected valid=%0b count=%0d",
               exp_tag, xfer_valid, xfer_count, exp_valid, exp_count);
    end
  endtask

  // One clock: judge the previous cycle's result, then drive new inputs.
  task automatic step(input string tag, input bit s, input logic [1:0] k,
                      input int w, input int i, input int o, input int b,
                      input int lid, input int dep, input int prv, input int nd,
                      input int idx, input int tot);
    @(negedge clk);
    compare();
    start = s; kind = k;
    weight_bytes = w; input_bytes = i; output_bytes = o; buf_bytes = b;
    layer_id = lid; dep_id = dep; prev_id = prv; next_dep_id = nd;
    layer_idx = idx; layer_total = tot;
    exp_valid = s;
    if (s) exp_count = model_count();
    exp_tag = tag;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: valid=%0b count=%0d expected run to end", xfer_valid, xfer_count);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(); // R1 during reset
    rst = 1'b0;
    // R1: first edge after release, nothing started
    step("R1", 0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R4: weights, exact and truncated, buffer and ids ignored
    step("R4", 1, 2'd0, 6400, 9999, 0, 100000, 3, 3, 3, 3, 2, 10);
    step("R4", 1, 2'd0, 100, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R3: inputs change, no strobe
    step("R3", 0, 2'd1, 64000, 64000, 64000, 0, 1, 2, 3, 4, 5, 6);
    step("R3", 0, 2'd2, 128, 128, 128, 0, 9, 9, 9, 9, 1, 3);
    // R10/R5: layer 0 with matching prev id still reads everything
    step("R10", 1, 2'd1, 0, 4096, 0, 8192, 4, 7, 7, 0, 0, 10);
    // R5: id mismatch
    step("R5", 1, 2'd1, 0, 4096, 0, 8192, 4, 7, 5, 0, 3, 10);
    // R6: fits and exactly equal
    step("R6", 1, 2'd1, 0, 512, 0, 1024, 4, 7, 7, 0, 3, 10);
    step("R6", 1, 2'd1, 0, 1024, 0, 1024, 4, 7, 7, 0, 3, 10);
    // R7: spill of one beat, and just under a beat
    step("R7", 1, 2'd1, 0, 1088, 0, 1024, 4, 7, 7, 0, 3, 10);
    step("R7", 1, 2'd1, 0, 1087, 0, 1024, 4, 7, 7, 0, 3, 10);
    // R8/R10: last layer with matching consumer
    step("R10", 1, 2'd2, 0, 0, 5000, 1024, 9, 8, 8, 9, 9, 10);
    step("R8", 1, 2'd2, 0, 0, 5000, 1024, 2, 1, 1, 6, 2, 10);
    // R9: linked fits, linked spills
    step("R9", 1, 2'd2, 0, 0, 1000, 1024, 2, 1, 1, 2, 2, 10);
    step("R9", 1, 2'd2, 0, 0, 5000, 1024, 2, 1, 1, 2, 2, 10);
    // R8: total of zero counts as last
    step("R8", 1, 2'd2, 0, 0, 640, 100000, 2, 1, 1, 2, 0, 0);
    // R11: unused kind
    step("R11", 1, 2'd3, 6400, 6400, 6400, 0, 1, 1, 1, 1, 1, 5);
    // R2/R3: idle then hold
    step("R2", 0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3", 0, 2'd1, 99999, 99999, 99999, 5, 1, 2, 2, 1, 4, 8);
    // R2: back-to-back strobes with differing kinds
    step("R2", 1, 2'd0, 640, 1280, 1920, 0, 1, 2, 2, 1, 4, 8);
    step("R2", 1, 2'd1, 640, 1280, 1920, 0, 1, 2, 2, 1, 4, 8);
    step("R2", 1, 2'd2, 640, 1280, 1920, 0, 1, 2, 2, 1, 4, 8);
    step("R2", 0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3", 0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule